// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register File

This block holds the software-visible state of an interrupt router. Software reaches it through two 32-bit registers on a small bus port: a select register picks an internal register, and a data window reads or writes the internal register that the select value names. The internal space has an identification register, a read-only version register, an arbitration register that mirrors the identification value, and a table of routing entries. Each routing entry is 64 bits wide and is reached as two 32-bit halves.

Every routing entry is presented in parallel to the delivery logic. The delivery logic owns two status bits in each entry, the delivery-status bit and the remote-IRR bit. It changes them through per-pin set and clear strobes, and software writes never alter them. A one-cycle pulse per pin tells the delivery logic that software has just rewritten that entry, so that it can re-evaluate the pin.

Top module: `irq_route_regfile`

## Requirements
- R1: An access takes effect only when `bus_size` is 4 and `bus_offset` is 0x00 (select) or 0x10 (window). Any other write changes no state and raises no pulse, and any other read returns zero.
- R2: A write at offset 0x00 stores all 32 bits of the select register. A read at offset 0x00 returns the stored value, and the value is zero after reset.
- R3: Only bits 7:0 of the select value choose the internal register. Internal indices outside 0x00–0x02 and 0x10–0x3F read as zero through the window, and writes to them have no effect.
- R4: Internal index 0x10+2p reaches bits 31:0 of entry p, and index 0x11+2p reaches bits 63:32 of entry p, for p from 0 to 23. Entry p appears on `entry_out[64p+63:64p]`.
- R5: A window write to the low half of an entry keeps bit 12 (delivery status) and bit 14 (remote IRR) at their current values and replaces every other bit of that half. A write to the high half replaces all 32 bits.
- R6: A set strobe for a pin forces that status bit to 1 and a clear strobe forces it to 0, visible the cycle after the strobe. When both strobes are high, set wins.
- R7: Index 0x01 (version) reads 0x00170011, which is the entry count minus one in bits 23:16 ORed with 0x11. Writes to it are ignored.
- R8: A write to index 0x00 (identification) keeps only bits 27:24 of the data and clears the rest. Index 0x02 (arbitration) reads the same value, and writes to index 0x02 are ignored.
- R9: After reset every entry holds 0x0001_0000_0001_0000, so bit 16 (mask) is set on every pin, and the identification register is zero.
- R10: A window write to either half of entry p drives `entry_wr_pulse[p]` high for exactly one cycle. That cycle is the one right after the write edge, and it is the same cycle in which the new contents first appear on `entry_out`. At most one pulse bit is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_offset | input | 8 | Byte offset of the access |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current request |
| entry_out | output | 1536 | All routing entries, entry p at bits 64p+63:64p |
| sts_set_dlv | input | 24 | Per-pin set strobe for the delivery-status bit |
| sts_clr_dlv | input | 24 | Per-pin clear strobe for the delivery-status bit |
| sts_set_rirr | input | 24 | Per-pin set strobe for the remote-IRR bit |
| sts_clr_rirr | input | 24 | Per-pin clear strobe for the remote-IRR bit |
| entry_wr_pulse | output | 24 | Per-pin one-cycle pulse after a software write to the entry |

## Verification
The properties take the bus request and the status strobes as settled single-cycle inputs that are sampled at the rising edge. They do not assume any spacing between accesses or any relation between strobes and bus writes. Under that assumption a software write and a status strobe can hit the same entry in the same cycle, and the status-bit properties still have to hold. The stimulus drives every input on the falling edge and holds each request or strobe for one full cycle. It reads the combinational read data before the next rising edge, so each request is seen by exactly one edge.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned IDX_W  = 8;

  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [2:0] SIZE_WORD = 3'd4;

  localparam logic [7:0] IDX_ID  = 8'h00;
  localparam logic [7:0] IDX_VER = 8'h01;
  localparam logic [7:0] IDX_ARB = 8'h02;
  localparam logic [7:0] IDX_TBL = 8'h10;

  localparam int unsigned DLV_BIT  = 12;
  localparam int unsigned RIRR_BIT = 14;

  localparam logic [31:0] LO_RO_MASK = 32'h0000_5000;
  localparam logic [31:0] ID_KEEP    = 32'h0F00_0000;
  localparam logic [63:0] ENTRY_RST  = 64'h0001_0000_0001_0000;

  // version word: highest entry number in 23:16, constant 0x11 below
  function automatic logic [31:0] ver_word(int unsigned n);
    logic [7:0] top;
    top = 8'(n - 1);
    return {8'h00, top, 16'h0011};
  endfunction

  // software half-write that leaves hardware-owned bits untouched
  function automatic logic [31:0] merge_half(logic [31:0] old_v,
                                             logic [31:0] new_v,
                                             logic [31:0] ro);
    return (new_v & ~ro) | (old_v & ro);
  endfunction

  function automatic logic in_table(logic [7:0] idx, int unsigned n);
    return (int'(idx) >= int'(IDX_TBL)) && (int'(idx) < int'(IDX_TBL) + 2 * int'(n));
  endfunction

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24,
  localparam int unsigned SLOT_W = $clog2(NUM_ENTRIES)
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [7:0]        bus_offset,
  input  logic [2:0]        bus_size,
  input  logic [7:0]        sel_idx,
  output logic              acc_ok,
  output logic              sel_wr,
  output logic              win_wr,
  output logic              is_tbl,
  output logic [SLOT_W-1:0] slot,
  output logic              hi_half
);

  logic       shape_ok;
  logic [7:0] rel;

  assign shape_ok = (bus_size == SIZE_WORD) &&
                    ((bus_offset == OFF_SEL) || (bus_offset == OFF_WIN));
  assign acc_ok   = bus_valid && shape_ok;
  assign sel_wr   = acc_ok && bus_write && (bus_offset == OFF_SEL);
  assign win_wr   = acc_ok && bus_write && (bus_offset == OFF_WIN);

  assign is_tbl  = in_table(sel_idx, NUM_ENTRIES);
  assign rel     = sel_idx - IDX_TBL;
  assign slot    = rel[SLOT_W:1];
  assign hi_half = rel[0];

endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        set_dlv,
  input  logic        clr_dlv,
  input  logic        set_rirr,
  input  logic        clr_rirr,
  output logic [63:0] entry,
  output logic        wr_pulse
);

  logic [63:0] nxt;

  always_comb begin
    nxt = entry;
    if (wr_lo) nxt[31:0]  = merge_half(entry[31:0], wdata, LO_RO_MASK);
    if (wr_hi) nxt[63:32] = wdata;
    if (clr_dlv)  nxt[DLV_BIT]  = 1'b0;
    if (set_dlv)  nxt[DLV_BIT]  = 1'b1;
    if (clr_rirr) nxt[RIRR_BIT] = 1'b0;
    if (set_rirr) nxt[RIRR_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry    <= ENTRY_RST;
      wr_pulse <= 1'b0;
    end else begin
      entry    <= nxt;
      wr_pulse <= wr_lo || wr_hi;
    end
  end

endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24,
  localparam int unsigned SLOT_W = $clog2(NUM_ENTRIES),
  localparam int unsigned ENT_W  = 2 * WORD_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_valid,
  input  logic                         bus_write,
  input  logic [7:0]                   bus_offset,
  input  logic [2:0]                   bus_size,
  input  logic [WORD_W-1:0]            bus_wdata,
  output logic [WORD_W-1:0]            bus_rdata,
  output logic [NUM_ENTRIES*ENT_W-1:0] entry_out,
  input  logic [NUM_ENTRIES-1:0]       sts_set_dlv,
  input  logic [NUM_ENTRIES-1:0]       sts_clr_dlv,
  input  logic [NUM_ENTRIES-1:0]       sts_set_rirr,
  input  logic [NUM_ENTRIES-1:0]       sts_clr_rirr,
  output logic [NUM_ENTRIES-1:0]       entry_wr_pulse
);

  logic [WORD_W-1:0] sel_q;
  logic [WORD_W-1:0] id_q;
  logic              acc_ok, sel_wr, win_wr, is_tbl, hi_half;
  logic [SLOT_W-1:0] slot;
  logic              ent_wr;
  logic              id_wr;
  logic [ENT_W-1:0]  ent_arr [NUM_ENTRIES];
  logic [WORD_W-1:0] win_rdata;

  irq_route_decode #(.NUM_ENTRIES(NUM_ENTRIES)) u_dec (
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_offset (bus_offset),
    .bus_size   (bus_size),
    .sel_idx    (sel_q[IDX_W-1:0]),
    .acc_ok     (acc_ok),
    .sel_wr     (sel_wr),
    .win_wr     (win_wr),
    .is_tbl     (is_tbl),
    .slot       (slot),
    .hi_half    (hi_half)
  );

  assign ent_wr = win_wr && is_tbl;
  assign id_wr  = win_wr && (sel_q[IDX_W-1:0] == IDX_ID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_wr) sel_q <= bus_wdata;
      if (id_wr)  id_q  <= bus_wdata & ID_KEEP;
    end
  end

  for (genvar p = 0; p < NUM_ENTRIES; p++) begin : g_ent
    logic hit;
    assign hit = ent_wr && (slot == SLOT_W'(p));
    irq_route_entry u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (hit && !hi_half),
      .wr_hi    (hit && hi_half),
      .wdata    (bus_wdata),
      .set_dlv  (sts_set_dlv[p]),
      .clr_dlv  (sts_clr_dlv[p]),
      .set_rirr (sts_set_rirr[p]),
      .clr_rirr (sts_clr_rirr[p]),
      .entry    (ent_arr[p]),
      .wr_pulse (entry_wr_pulse[p])
    );
    assign entry_out[p*ENT_W +: ENT_W] = ent_arr[p];
  end

  always_comb begin
    win_rdata = '0;
    unique case (sel_q[IDX_W-1:0])
      IDX_ID:  win_rdata = id_q;
      IDX_VER: win_rdata = ver_word(NUM_ENTRIES);
      IDX_ARB: win_rdata = id_q;
      default: begin
        if (is_tbl)
          win_rdata = hi_half ? ent_arr[slot][63:32] : ent_arr[slot][31:0];
      end
    endcase
  end

  always_comb begin
    bus_rdata = '0;
    if (acc_ok && !bus_write)
      bus_rdata = (bus_offset == OFF_SEL) ? sel_q : win_rdata;
  end

endmodule

// File: rtl/irq_route_regfile_chk.sv
module irq_route_regfile_chk
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_valid,
  input logic                          bus_write,
  input logic [7:0]                    bus_offset,
  input logic [2:0]                    bus_size,
  input logic [31:0]                   bus_rdata,
  input logic [NUM_ENTRIES*64-1:0]     entry_out,
  input logic [NUM_ENTRIES-1:0]        sts_set_dlv,
  input logic [NUM_ENTRIES-1:0]        sts_clr_dlv,
  input logic [NUM_ENTRIES-1:0]        sts_set_rirr,
  input logic [NUM_ENTRIES-1:0]        sts_clr_rirr,
  input logic [NUM_ENTRIES-1:0]        entry_wr_pulse,
  input logic [31:0]                   sel_q,
  input logic                          sel_wr,
  input logic                          ent_wr
);

  logic bad_rd;
  assign bad_rd = bus_valid && !bus_write &&
                  ((bus_size != SIZE_WORD) ||
                   ((bus_offset != OFF_SEL) && (bus_offset != OFF_WIN)));

  // R1
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_rd |-> (bus_rdata == 32'h0));

  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(sel_q));

  // R10
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(entry_wr_pulse));

  // R10
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|entry_wr_pulse) |-> $past(ent_wr));

  for (genvar p = 0; p < NUM_ENTRIES; p++) begin : g_pin
    // R6
    dlv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sts_set_dlv[p] |=> entry_out[p*64 + DLV_BIT]);
    // R6
    dlv_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_clr_dlv[p] && !sts_set_dlv[p]) |=> !entry_out[p*64 + DLV_BIT]);
    // R5
    dlv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts_clr_dlv[p] && !sts_set_dlv[p]) |=> $stable(entry_out[p*64 + DLV_BIT]));
    // R6
    rirr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sts_set_rirr[p] |=> entry_out[p*64 + RIRR_BIT]);
    // R6
    rirr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_clr_rirr[p] && !sts_set_rirr[p]) |=> !entry_out[p*64 + RIRR_BIT]);
    // R5
    rirr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts_clr_rirr[p] && !sts_set_rirr[p]) |=> $stable(entry_out[p*64 + RIRR_BIT]));
  end

endmodule

bind irq_route_regfile irq_route_regfile_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_valid      (bus_valid),
  .bus_write      (bus_write),
  .bus_offset     (bus_offset),
  .bus_size       (bus_size),
  .bus_rdata      (bus_rdata),
  .entry_out      (entry_out),
  .sts_set_dlv    (sts_set_dlv),
  .sts_clr_dlv    (sts_clr_dlv),
  .sts_set_rirr   (sts_set_rirr),
  .sts_clr_rirr   (sts_clr_rirr),
  .entry_wr_pulse (entry_wr_pulse),
  .sel_q          (sel_q),
  .sel_wr         (sel_wr),
  .ent_wr         (ent_wr)
);

// File: tb/irq_route_regfile_test.sv
module irq_route_regfile_test;

  localparam int N = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [7:0]    bus_offset = '0;
  logic [2:0]    bus_size = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N*64-1:0] entry_out;
  logic [N-1:0]  sts_set_dlv = '0, sts_clr_dlv = '0, sts_set_rirr = '0, sts_clr_rirr = '0;
  logic [N-1:0]  entry_wr_pulse;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] pulse_snap;

  always #5 clk = ~clk;

  irq_route_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_offset(bus_offset), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .entry_out(entry_out),
    .sts_set_dlv(sts_set_dlv), .sts_clr_dlv(sts_clr_dlv),
    .sts_set_rirr(sts_set_rirr), .sts_clr_rirr(sts_clr_rirr),
    .entry_wr_pulse(entry_wr_pulse)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ent(int p);
    return entry_out[p*64 +: 64];
  endfunction

  task automatic bus_wr(logic [7:0] off, logic [2:0] sz, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_offset = off; bus_size = sz; bus_wdata = d;
    @(posedge clk);
    #1;
    pulse_snap = entry_wr_pulse;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] off, logic [2:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_offset = off; bus_size = sz;
    #1;
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic win_rd(logic [31:0] sel, output logic [31:0] d);
    bus_wr(8'h00, 3'd4, sel);
    bus_rd(8'h10, 3'd4, d);
  endtask

  task automatic strobe(int p, logic sd, logic cd, logic sr, logic cr);
    @(negedge clk);
    sts_set_dlv[p] = sd; sts_clr_dlv[p] = cd; sts_set_rirr[p] = sr; sts_clr_rirr[p] = cr;
    @(posedge clk);
    #1;
    sts_set_dlv = '0; sts_clr_dlv = '0; sts_set_rirr = '0; sts_clr_rirr = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R9 entry0 reset", ent(0), 64'h0001_0000_0001_0000);
    check("R9 entry23 reset", ent(23), 64'h0001_0000_0001_0000);
    check("R10 no pulse at reset", {40'h0, entry_wr_pulse}, 64'h0);
    bus_rd(8'h00, 3'd4, d);
    check("R2 select reset zero", {32'h0, d}, 64'h0);
    bus_rd(8'h10, 3'd4, d);
    check("R9 id reset zero", {32'h0, d}, 64'h0);
  endtask

  task automatic t_select();
    logic [31:0] d;
    bus_wr(8'h00, 3'd4, 32'hDEAD_BE10);
    bus_rd(8'h00, 3'd4, d);
    check("R2 select readback", {32'h0, d}, 64'hDEAD_BE10);
  endtask

  task automatic t_entry();
    logic [31:0] d;
    bus_wr(8'h00, 3'd4, 32'h0000_001A);
    bus_wr(8'h10, 3'd4, 32'hFFFF_FFFF);
    check("R10 pulse pin5 low write", {40'h0, pulse_snap}, 64'h1 << 5);
    check("R5 low half ro kept", ent(5), 64'h0001_0000_FFFF_AFFF);
    @(posedge clk); #1;
    check("R10 pulse one cycle", {40'h0, entry_wr_pulse}, 64'h0);
    bus_wr(8'h00, 3'd4, 32'hFFFF_FF1B);
    bus_wr(8'h10, 3'd4, 32'hAB00_0000);
    check("R3 high bits of select ignored", ent(5), 64'hAB00_0000_FFFF_AFFF);
    check("R10 pulse pin5 high write", {40'h0, pulse_snap}, 64'h1 << 5);
    bus_rd(8'h10, 3'd4, d);
    check("R4 high half readback", {32'h0, d}, 64'hAB00_0000);
    win_rd(32'h1A, d);
    check("R4 low half readback", {32'h0, d}, 64'hFFFF_AFFF);
    bus_wr(8'h00, 3'd4, 32'h0000_003F);
    bus_wr(8'h10, 3'd4, 32'h1234_5678);
    check("R4 last entry high", ent(23), 64'h1234_5678_0001_0000);
    check("R4 neighbour untouched", ent(22), 64'h0001_0000_0001_0000);
  endtask

  task automatic t_status();
    strobe(3, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R6 set both status", ent(3), 64'h0001_0000_0001_5000);
    bus_wr(8'h00, 3'd4, 32'h0000_0016);
    bus_wr(8'h10, 3'd4, 32'h0000_0000);
    check("R5 write keeps set status", ent(3), 64'h0001_0000_0000_5000);
    strobe(3, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R6 clear dlv only", ent(3), 64'h0001_0000_0000_4000);
    strobe(3, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R6 set wins and rirr clear", ent(3), 64'h0001_0000_0000_1000);
  endtask

  task automatic t_id_ver();
    logic [31:0] d;
    win_rd(32'h01, d);
    check("R7 version value", {32'h0, d}, 64'h0017_0011);
    bus_wr(8'h10, 3'd4, 32'h0);
    bus_rd(8'h10, 3'd4, d);
    check("R7 version write ignored", {32'h0, d}, 64'h0017_0011);
    bus_wr(8'h00, 3'd4, 32'h00);
    bus_wr(8'h10, 3'd4, 32'hFFFF_FFFF);
    bus_rd(8'h10, 3'd4, d);
    check("R8 id keeps 27:24", {32'h0, d}, 64'h0F00_0000);
    bus_wr(8'h00, 3'd4, 32'h02);
    bus_wr(8'h10, 3'd4, 32'h0);
    bus_rd(8'h10, 3'd4, d);
    check("R8 arb mirrors id, write ignored", {32'h0, d}, 64'h0F00_0000);
  endtask

  task automatic t_bad();
    logic [31:0] d;
    bus_wr(8'h00, 3'd4, 32'h0000_0012);
    bus_wr(8'h00, 3'd2, 32'h0000_0055);
    bus_rd(8'h00, 3'd4, d);
    check("R1 short select write ignored", {32'h0, d}, 64'h12);
    bus_wr(8'h10, 3'd2, 32'h0);
    check("R1 short window write no pulse", {40'h0, pulse_snap}, 64'h0);
    check("R1 short window write no change", ent(1), 64'h0001_0000_0001_0000);
    bus_wr(8'h04, 3'd4, 32'h0);
    bus_wr(8'h14, 3'd4, 32'h0);
    check("R1 bad offset write no change", ent(1), 64'h0001_0000_0001_0000);
    bus_rd(8'h10, 3'd1, d);
    check("R1 short read zero", {32'h0, d}, 64'h0);
    bus_rd(8'h08, 3'd4, d);
    check("R1 bad offset read zero", {32'h0, d}, 64'h0);
    bus_rd(8'h10, 3'd4, d);
    check("R1 proper read works", {32'h0, d}, 64'h0001_0000);
  endtask

  task automatic t_unimpl();
    logic [31:0] d;
    win_rd(32'h40, d);
    check("R3 index 0x40 reads zero", {32'h0, d}, 64'h0);
    bus_wr(8'h10, 3'd4, 32'hFFFF_FFFF);
    check("R3 index 0x40 write no pulse", {40'h0, pulse_snap}, 64'h0);
    check("R3 entry0 untouched", ent(0), 64'h0001_0000_0001_0000);
    win_rd(32'h0F, d);
    check("R3 index 0x0F reads zero", {32'h0, d}, 64'h0);
    win_rd(32'h05, d);
    check("R3 index 0x05 reads zero", {32'h0, d}, 64'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_select();
    t_entry();
    t_status();
    t_id_ver();
    t_bad();
    t_unimpl();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule